// File: doc/BRIEF.md
# Transparent Clock Residence-Time Corrector

This block sits in the forwarding path of a switch and adds to each time-event message the time that message spent inside the device. When an event message enters, the ingress side raises a strobe with a small packet tag and the ingress timestamp, and the block stores that timestamp in a slot chosen by the tag. When the same message is about to leave, the egress side presents the tag, the correction value carried in the message and the egress timestamp. One cycle later the block returns the new correction value.

The residence time is the egress timestamp minus the stored ingress timestamp. It is taken modulo the timestamp width, so a counter wrap between ingress and egress still gives the right result. The correction value is in nanoseconds scaled by 2^16. The residence time is shifted left by the same 16 bits and added to the incoming value, so corrections from earlier bridges are kept. The origin timestamp of the message is never seen or changed here. Each tag has its own slot, so messages that interleave each get their own residence time. A slot is released when its result is emitted. An egress request for an empty slot returns the incoming correction unchanged and raises an error flag.

Top module: `tc_residence_corrector`

## Requirements
- R1: After reset every slot is empty and out_valid and out_err are 0; an egress request for any tag before any ingress returns an error.
- R2: out_valid is 1 in exactly the cycle after a cycle with egr_valid = 1, and 0 otherwise.
- R3: For a tag with a stored stamp, out_corr = (egr_corr_in + (((egr_ts - stamp) mod 2^48) << 16)) mod 2^64 and out_err = 0; the low 16 bits of the correction are unchanged.
- R4: The residence time is computed modulo 2^48, so an egress timestamp that wrapped past zero after ingress gives the short positive distance.
- R5: The residence time is added to the incoming correction, never written over it, and the 64-bit sum wraps modulo 2^64.
- R6: For a tag with no stored stamp, out_corr equals egr_corr_in and out_err is 1.
- R7: A slot is released at the clock edge on which its result is registered, so a second egress for the same tag without a new ingress returns an error.
- R8: The eight tags (3-bit tag value 0 to 7) hold independent stamps; ingress and egress on other tags never change a slot's stamp.
- R9: A new ingress on a tag that already holds a stamp replaces the stored stamp.
- R10: When ingress and egress name the same tag in the same cycle, the egress uses the stamp stored before that cycle, and the slot then holds the new ingress stamp.
- R11: out_err is 1 only while out_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ing_valid | input | 1 | Ingress timestamp strobe |
| ing_tag | input | 3 | Slot tag of the arriving message |
| ing_ts | input | 48 | Ingress timestamp in nanoseconds |
| egr_valid | input | 1 | Egress request strobe |
| egr_tag | input | 3 | Slot tag of the departing message |
| egr_corr_in | input | 64 | Incoming correction, ns scaled by 2^16 |
| egr_ts | input | 48 | Egress timestamp in nanoseconds |
| out_valid | output | 1 | Result valid, one cycle after egr_valid |
| out_corr | output | 64 | Updated correction value |
| out_err | output | 1 | Egress tag had no stored stamp |

## Verification
The bench sweeps all eight tags in several interleaved orders and with many residence times. It checks that each tag gets its own stamp back; a design that indexed slots wrongly would add another message's residence time. It drives timestamp wrap and correction overflow values. A design that used a signed or wider subtraction would give a huge residence time, and one that overwrote the correction instead of adding to it would lose the upstream value. It also repeats egress on a released tag, re-stamps a tag that is still held, and drives ingress and egress on the same tag in one cycle. These catch a slot that is never freed, a stale stamp that is kept, and a wrong priority between storing and freeing a slot in the same cycle.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  localparam int unsigned TAG_W_DEF  = 3;
  localparam int unsigned TS_W_DEF   = 48;
  localparam int unsigned CORR_W_DEF = 64;
  localparam int unsigned SHIFT_DEF  = 16;
endpackage

// File: rtl/tcr_slot.sv
module tcr_slot #(
  parameter int unsigned TS_W = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            store,
  input  logic            release_i,
  input  logic [TS_W-1:0] store_ts,
  output logic            held,
  output logic [TS_W-1:0] stamp
);
  logic            held_d, held_q;
  logic [TS_W-1:0] stamp_q;

  // store wins over release for the same cycle
  always_comb begin
    held_d = held_q;
    if (release_i) held_d = 1'b0;
    if (store)     held_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else        held_q <= held_d;
  end

  always_ff @(posedge clk) begin
    if (store) stamp_q <= store_ts;
  end

  assign held  = held_q;
  assign stamp = stamp_q;
endmodule

// File: rtl/tcr_stamp_table.sv
module tcr_stamp_table #(
  parameter int unsigned TAG_W = 3,
  parameter int unsigned TS_W  = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ing_valid,
  input  logic [TAG_W-1:0] ing_tag,
  input  logic [TS_W-1:0]  ing_ts,
  input  logic             egr_valid,
  input  logic [TAG_W-1:0] egr_tag,
  output logic             look_hit,
  output logic [TS_W-1:0]  look_stamp
);
  localparam int unsigned SLOTS = 1 << TAG_W;

  logic [SLOTS-1:0] held_vec;
  logic [TS_W-1:0]  stamp_arr [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic store_i, rel_i;
    assign store_i = ing_valid && (ing_tag == TAG_W'(i));
    assign rel_i   = egr_valid && (egr_tag == TAG_W'(i));
    tcr_slot #(.TS_W(TS_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .store     (store_i),
      .release_i (rel_i),
      .store_ts  (ing_ts),
      .held      (held_vec[i]),
      .stamp     (stamp_arr[i])
    );
  end

  // lookup sees the state before this cycle's store
  assign look_hit   = held_vec[egr_tag];
  assign look_stamp = stamp_arr[egr_tag];
endmodule

// File: rtl/tcr_corr_stage.sv
module tcr_corr_stage #(
  parameter int unsigned TS_W   = 48,
  parameter int unsigned CORR_W = 64,
  parameter int unsigned SHIFT  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              egr_valid,
  input  logic [CORR_W-1:0] egr_corr_in,
  input  logic [TS_W-1:0]   egr_ts,
  input  logic              look_hit,
  input  logic [TS_W-1:0]   look_stamp,
  output logic              out_valid,
  output logic [CORR_W-1:0] out_corr,
  output logic              out_err
);
  localparam int unsigned EXT_W = (TS_W > CORR_W) ? TS_W : CORR_W;

  logic [TS_W-1:0]   resid;
  logic [EXT_W-1:0]  resid_ext;
  logic [CORR_W-1:0] resid_scaled;
  logic              valid_d, err_d, valid_q, err_q;
  logic [CORR_W-1:0] corr_d, corr_q;

  always_comb begin
    resid        = egr_ts - look_stamp;
    resid_ext    = EXT_W'(resid);
    resid_scaled = CORR_W'(resid_ext << SHIFT);
    valid_d      = egr_valid;
    err_d        = egr_valid && !look_hit;
    corr_d       = look_hit ? (egr_corr_in + resid_scaled) : egr_corr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (egr_valid) corr_q <= corr_d;
  end

  assign out_valid = valid_q;
  assign out_err   = err_q;
  assign out_corr  = corr_q;
endmodule

// File: rtl/tc_residence_corrector.sv
module tc_residence_corrector #(
  parameter int unsigned TAG_W  = tcr_pkg::TAG_W_DEF,
  parameter int unsigned TS_W   = tcr_pkg::TS_W_DEF,
  parameter int unsigned CORR_W = tcr_pkg::CORR_W_DEF,
  parameter int unsigned SHIFT  = tcr_pkg::SHIFT_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ing_valid,
  input  logic [TAG_W-1:0]  ing_tag,
  input  logic [TS_W-1:0]   ing_ts,
  input  logic              egr_valid,
  input  logic [TAG_W-1:0]  egr_tag,
  input  logic [CORR_W-1:0] egr_corr_in,
  input  logic [TS_W-1:0]   egr_ts,
  output logic              out_valid,
  output logic [CORR_W-1:0] out_corr,
  output logic              out_err
);
  logic            look_hit;
  logic [TS_W-1:0] look_stamp;

  tcr_stamp_table #(.TAG_W(TAG_W), .TS_W(TS_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .ing_valid  (ing_valid),
    .ing_tag    (ing_tag),
    .ing_ts     (ing_ts),
    .egr_valid  (egr_valid),
    .egr_tag    (egr_tag),
    .look_hit   (look_hit),
    .look_stamp (look_stamp)
  );

  tcr_corr_stage #(.TS_W(TS_W), .CORR_W(CORR_W), .SHIFT(SHIFT)) u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .egr_valid   (egr_valid),
    .egr_corr_in (egr_corr_in),
    .egr_ts      (egr_ts),
    .look_hit    (look_hit),
    .look_stamp  (look_stamp),
    .out_valid   (out_valid),
    .out_corr    (out_corr),
    .out_err     (out_err)
  );
endmodule

// File: rtl/tcr_checker.sv
module tcr_checker #(
  parameter int unsigned CORR_W = 64,
  parameter int unsigned SHIFT  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              egr_valid,
  input logic [CORR_W-1:0] egr_corr_in,
  input logic              out_valid,
  input logic [CORR_W-1:0] out_corr,
  input logic              out_err
);
  // R2: a result follows every egress request
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    egr_valid |=> out_valid);

  // R2: no result without a request
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !egr_valid |=> !out_valid);

  // R11: error only alongside a result
  a_r11_err_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid);

  // R6: missing stamp passes the correction through
  a_r6_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_corr == $past(egr_corr_in)));

  // R3: fractional nanosecond bits are not touched
  a_r3_frac_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err) |-> (out_corr[SHIFT-1:0] == $past(egr_corr_in[SHIFT-1:0])));
endmodule

bind tc_residence_corrector tcr_checker #(.CORR_W(CORR_W), .SHIFT(SHIFT)) u_tcr_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .egr_valid   (egr_valid),
  .egr_corr_in (egr_corr_in),
  .out_valid   (out_valid),
  .out_corr    (out_corr),
  .out_err     (out_err)
);

// File: tb/test_tc_residence_corrector.sv
module test_tc_residence_corrector;
  logic        clk;
  logic        rst_n;
  logic        ing_valid;
  logic [2:0]  ing_tag;
  logic [47:0] ing_ts;
  logic        egr_valid;
  logic [2:0]  egr_tag;
  logic [63:0] egr_corr_in;
  logic [47:0] egr_ts;
  logic        out_valid;
  logic [63:0] out_corr;
  logic        out_err;

  int checks = 0;
  int fails  = 0;

  // bench model of slot contents, derived from the requirements
  bit          m_held [8];
  logic [47:0] m_ts   [8];

  tc_residence_corrector i_tc_residence_corrector (
    .clk(clk), .rst_n(rst_n),
    .ing_valid(ing_valid), .ing_tag(ing_tag), .ing_ts(ing_ts),
    .egr_valid(egr_valid), .egr_tag(egr_tag), .egr_corr_in(egr_corr_in), .egr_ts(egr_ts),
    .out_valid(out_valid), .out_corr(out_corr), .out_err(out_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock cycle of stimulus; checks the registered result after the edge.
  task automatic cyc(input bit iv, input logic [2:0] it, input logic [47:0] its,
                     input bit ev, input logic [2:0] et, input logic [63:0] ec,
                     input logic [47:0] ets, input string req);
    logic        exp_err;
    logic [63:0] exp_corr;
    logic [47:0] res;
    @(negedge clk);
    ing_valid = iv; ing_tag = it; ing_ts = its;
    egr_valid = ev; egr_tag = et; egr_corr_in = ec; egr_ts = ets;
    exp_err  = !m_held[et];
    res      = ets - m_ts[et];
    exp_corr = exp_err ? ec : ec + ({16'h0, res} << 16);
    @(posedge clk);
    #1;
    chk(out_valid == ev, req, {63'h0, out_valid}, {63'h0, ev});
    if (ev) begin
      chk(out_err == exp_err, req, {63'h0, out_err}, {63'h0, exp_err});
      chk(out_corr == exp_corr, req, out_corr, exp_corr);
    end else begin
      chk(out_err == 1'b0, "R11", {63'h0, out_err}, 64'h0);
    end
    if (ev) m_held[et] = 1'b0;
    if (iv) begin m_held[it] = 1'b1; m_ts[it] = its; end
  endtask

  task automatic ing(input logic [2:0] t, input logic [47:0] ts, input string req);
    cyc(1'b1, t, ts, 1'b0, 3'd0, 64'h0, 48'h0, req);
  endtask

  task automatic egr(input logic [2:0] t, input logic [63:0] c, input logic [47:0] ts, input string req);
    cyc(1'b0, 3'd0, 48'h0, 1'b1, t, c, ts, req);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin m_held[i] = 1'b0; m_ts[i] = 48'h0; end
    rst_n = 1'b0; ing_valid = 1'b0; ing_tag = '0; ing_ts = '0;
    egr_valid = 1'b0; egr_tag = '0; egr_corr_in = '0; egr_ts = '0;
    #1;
    chk(out_valid == 1'b0 && out_err == 1'b0, "R1", {62'h0, out_valid, out_err}, 64'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every slot empty after reset
    cyc(1'b0, 3'd0, 48'h0, 1'b0, 3'd0, 64'h0, 48'h0, "R2");
    for (int t = 0; t < 8; t++) egr(3'(t), 64'h1234_0000_0000_abcd + 64'(t), 48'h55, "R1");

    // R3 R8: stamp all tags, release in reverse order with varied delays
    for (int t = 0; t < 8; t++) ing(3'(t), 48'h1000 + 48'(t * 777), "R8");
    for (int t = 7; t >= 0; t--)
      egr(3'(t), 64'(t) * 64'h0001_0000_0003 + 64'h7777, 48'h9000 + 48'(t * t * 31), "R3");

    // R7: released slots report an error
    for (int t = 0; t < 8; t++) egr(3'(t), 64'h0000_00ff_0000_0042, 48'h1, "R7");

    // R8: interleaved sweep, odd tags out first, many residence values
    for (int k = 0; k < 40; k++) begin
      for (int t = 0; t < 8; t++) ing(3'(t), 48'(k * 100003 + t * 17), "R8");
      for (int t = 1; t < 8; t += 2) egr(3'(t), 64'(k) << 20, 48'(k * 100003 + 5000 + t * 91), "R8");
      for (int t = 0; t < 8; t += 2) egr(3'(t), 64'h0000_0005_0000_0001, 48'(k * 100003 + k * k), "R3");
    end

    // R4: timestamp wraps between ingress and egress
    ing(3'd2, 48'hFFFF_FFFF_FFF0, "R4");
    egr(3'd2, 64'h0000_0000_0001_0000, 48'h0000_0000_0010, "R4");

    // R5: correction sum wraps
    ing(3'd5, 48'h100, "R5");
    egr(3'd5, 64'hFFFF_FFFF_FFFF_1234, 48'h1FF, "R5");

    // R9: re-stamp replaces the held stamp
    ing(3'd6, 48'h10, "R9");
    ing(3'd6, 48'h500, "R9");
    egr(3'd6, 64'h0, 48'h600, "R9");

    // R10: same-cycle ingress and egress on one tag
    ing(3'd4, 48'h2000, "R10");
    cyc(1'b1, 3'd4, 48'h3000, 1'b1, 3'd4, 64'h42, 48'h2800, "R10");
    egr(3'd4, 64'h0, 48'h3100, "R10");
    cyc(1'b1, 3'd1, 48'h700, 1'b1, 3'd1, 64'h99, 48'h800, "R10");
    egr(3'd1, 64'h0, 48'h900, "R10");

    // R6: unknown tag passes the value through
    egr(3'd3, 64'hDEAD_BEEF_CAFE_F00D, 48'h1234, "R6");

    // R2 R11: idle cycles give no result
    for (int i = 0; i < 3; i++) cyc(1'b0, 3'd0, 48'h0, 1'b0, 3'd0, 64'h0, 48'h0, "R2");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule